// File: doc/BRIEF.md
# Binary Field Serial Divider

This block divides one element of GF(2^N) by another. Both operands and the quotient are N-bit vectors in polynomial basis: bit i holds the coefficient of x^i. The field is fixed when the block is elaborated. The reduction polynomial is either x^N + x^K1 + 1 or x^N + x^K3 + x^K2 + x^K1 + 1, and a parameter picks which one.

The quotient is formed as A·B^(2^N−2). The block runs N−1 multiplication passes. Each pass first squares the running value and then multiplies it by one serial operand, taking one coefficient per clock, most significant first. That operand is B in every pass except the last, where it is A. The running value starts as B, so the first N−2 passes build B^(2^(N−1)−1). The last pass squares that value and multiplies it by A. Each pass lasts N clocks, so a division takes N(N−1) clocks.

A single N-cell multiply-accumulate row does the work. On each clock it shifts the accumulator left, folds the bit that falls out back in through the sparse feedback taps, and adds the parallel operand when the serial coefficient is 1. A control unit sequences the passes and holds the operands. A host pulses `start` with the operands applied and waits for the one-cycle `done` strobe.

Top module: `gf2m_serial_divider`

## Requirements
- R1: When `done` is high, `c` equals A·B^−1 reduced modulo the configured polynomial, for the A and B present on the cycle `start` was accepted, for any nonzero B.
- R2: `done` is high for exactly one cycle, after the N(N−1)-th rising clock edge that follows the edge accepting `start`.
- R3: While a division is running, `start` is ignored. A request made mid-computation changes neither the result nor the timing of the division in progress, and it produces no later division of its own.
- R4: Between `done` and the next accepted `start`, `c` holds the quotient, even when `a` and `b` change.
- R5: When B is zero, the block returns `c` = 0 after the normal latency and signals nothing else.
- R6: When B = 1 the quotient equals A, and when A = 0 the quotient is 0.
- R7: During and directly after reset, `done` is 0 and `c` is all zeros.
- R8: With the trinomial option (a single middle term K1), the block divides correctly in a small field (N = 7, K1 = 1) with the same timing rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only when idle |
| a | input | N | Dividend, sampled when start is accepted |
| b | input | N | Divisor, sampled when start is accepted |
| c | output | N | Quotient; valid from done until the next accepted start |
| done | output | 1 | One-cycle strobe marking a valid quotient |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a pass. In that case the sequencer must keep its counters and the operand registers must keep the first operands. The small-field bench raises `start` with different operands a few cycles into a running division. It then checks three things: the quotient is that of the first operands, the latency is still counted from the first request, and no second strobe follows. In the large field, a few full divisions of about 26,000 cycles each run against an extended-Euclid reference, including the B = 0 and B = 1 cases.

// File: rtl/gf2m_div_pkg.sv
package gf2m_div_pkg;

    // Phase of the pass sequencer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/gf2m_squarer.sv
// Combinational squaring in polynomial basis. The coefficients are spread
// to even positions, then every term of degree N or above is folded down
// through the sparse low-order mask of the reduction polynomial.
module gf2m_squarer #(
    parameter int unsigned N            = 163,
    parameter logic [N-1:0] RED_MASK    = '0
) (
    input  logic [N-1:0] sq_in,
    output logic [N-1:0] sq_out
);

    localparam int unsigned SPREAD_W = 2 * N - 1;

    logic [SPREAD_W-1:0] wide;

    always_comb begin
        wide = '0;
        for (int i = 0; i < N; i++) begin
            wide[2*i] = sq_in[i];
        end
        // Top-down folding: each fold only creates lower-degree terms.
        for (int j = SPREAD_W - 1; j >= N; j--) begin
            if (wide[j]) begin
                wide[j] = 1'b0;
                wide[j-N +: N] = wide[j-N +: N] ^ RED_MASK;
            end
        end
        sq_out = wide[N-1:0];
    end

endmodule

// File: rtl/gf2m_mac_row.sv
// One clock of an MSB-first serial multiplication: acc <- acc*x + ybit*xop
// modulo the field polynomial. One cell per coefficient; the generate picks
// a cell with or without a feedback tap from the constant mask.
module gf2m_mac_row #(
    parameter int unsigned N         = 163,
    parameter logic [N-1:0] RED_MASK = '0
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] xop,
    input  logic         ybit,
    output logic [N-1:0] nxt
);

    logic carry_out;

    assign carry_out = acc[N-1];

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == 0) begin : g_lsb
            assign nxt[i] = (carry_out & RED_MASK[i]) ^ (ybit & xop[i]);
        end else if (RED_MASK[i]) begin : g_tap
            assign nxt[i] = acc[i-1] ^ carry_out ^ (ybit & xop[i]);
        end else begin : g_plain
            assign nxt[i] = acc[i-1] ^ (ybit & xop[i]);
        end
    end

endmodule

// File: rtl/gf2m_div_seq.sv
// Pass sequencer: N-1 passes of N serial steps each, then a done strobe.
module gf2m_div_seq
    import gf2m_div_pkg::*;
#(
    parameter int unsigned N = 163
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  accept,
    output logic                  run,
    output logic                  final_pass,
    output logic                  pass_end,
    output logic [$clog2(N)-1:0]  bit_idx,
    output logic                  done
);

    localparam int unsigned CW       = $clog2(N);
    localparam logic [CW-1:0] TOP_BIT  = CW'(N - 1);
    localparam logic [CW-1:0] LAST_PASS = CW'(N - 2);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] pass_cnt;
        logic [CW-1:0] bidx;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase    = PH_RUN;
                    s_d.pass_cnt = '0;
                    s_d.bidx     = TOP_BIT;
                end
            end
            PH_RUN: begin
                if (s_q.bidx == '0) begin
                    if (s_q.pass_cnt == LAST_PASS) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.pass_cnt = s_q.pass_cnt + 1'b1;
                        s_d.bidx     = TOP_BIT;
                    end
                end else begin
                    s_d.bidx = s_q.bidx - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run        = (s_q.phase == PH_RUN);
    assign accept     = start && !run;
    assign final_pass = (s_q.pass_cnt == LAST_PASS);
    assign pass_end   = run && (s_q.bidx == '0);
    assign bit_idx    = s_q.bidx;
    assign done       = s_q.done;

    // R2: the strobe never lasts two cycles.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: inside a pass the coefficient index falls by one per clock.
    p_bit_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_idx != '0) |=> (run && bit_idx == $past(bit_idx) - 1'b1));

    // R2: the last step of the last pass leads straight to the strobe.
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && final_pass) |=> (done && !run));

    // R3: a request while running leaves the pass counter alone.
    p_busy_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && bit_idx != '0) |=> (run && $stable(s_q.pass_cnt)));

endmodule

// File: rtl/gf2m_serial_divider.sv
// GF(2^N) divider: C = A * B^(2^N - 2) via N-1 square-then-multiply passes.
module gf2m_serial_divider #(
    parameter int unsigned N     = 163,
    parameter int unsigned K1    = 3,
    parameter int unsigned K2    = 6,
    parameter int unsigned K3    = 7,
    parameter bit          PENTA = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] c,
    output logic         done
);

    localparam int unsigned CW = $clog2(N);
    localparam logic [N-1:0] ONE_N = N'(1);
    // Low-order part of the reduction polynomial (x^N excluded).
    localparam logic [N-1:0] RED_MASK = ONE_N | (ONE_N << K1) |
        (PENTA ? ((ONE_N << K2) | (ONE_N << K3)) : '0);

    typedef struct packed {
        logic [N-1:0] opa;
        logic [N-1:0] opb;
        logic [N-1:0] xsq;
        logic [N-1:0] acc;
    } dp_t;

    dp_t dp_d, dp_q;

    logic          accept;
    logic          run;
    logic          final_pass;
    logic          pass_end;
    logic [CW-1:0] bit_idx;
    logic          ybit;
    logic [N-1:0]  row_out;
    logic [N-1:0]  sq_src;
    logic [N-1:0]  sq_out;

    gf2m_div_seq #(.N(N)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .accept     (accept),
        .run        (run),
        .final_pass (final_pass),
        .pass_end   (pass_end),
        .bit_idx    (bit_idx),
        .done       (done)
    );

    // Serial operand row: B for the inner passes, A for the last one.
    assign ybit = final_pass ? dp_q.opa[bit_idx] : dp_q.opb[bit_idx];

    gf2m_mac_row #(.N(N), .RED_MASK(RED_MASK)) row_i (
        .acc  (dp_q.acc),
        .xop  (dp_q.xsq),
        .ybit (ybit),
        .nxt  (row_out)
    );

    // Square the divisor at load, or the finished product at a pass end.
    assign sq_src = accept ? b : row_out;

    gf2m_squarer #(.N(N), .RED_MASK(RED_MASK)) sq_i (
        .sq_in  (sq_src),
        .sq_out (sq_out)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.opa = a;
            dp_d.opb = b;
            dp_d.xsq = sq_out;
            dp_d.acc = '0;
        end else if (run) begin
            if (pass_end && !final_pass) begin
                dp_d.xsq = sq_out;
                dp_d.acc = '0;
            end else begin
                dp_d.acc = row_out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign c = dp_q.acc;

    // R4: while idle and not restarted the quotient does not move.
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(c));

    // R3: operands captured at acceptance survive any request while busy.
    p_operands_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(dp_q.opa) && $stable(dp_q.opb)));

    // R5: a zero divisor keeps every partial product at zero.
    p_zero_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dp_q.opb == '0) |-> (dp_q.acc == '0));

    // R7: nothing is announced in the cycle after a fresh acceptance.
    p_no_early_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);

endmodule

// File: tb/gf2m_div_harness.sv
// Drives one divider instance and compares it with an extended-Euclid model.
module gf2m_div_harness #(
    parameter int unsigned N       = 163,
    parameter int unsigned K1      = 3,
    parameter int unsigned K2      = 6,
    parameter int unsigned K3      = 7,
    parameter bit          PENTA   = 1'b1,
    parameter int unsigned NUM_VEC = 3,
    parameter bit          SMALL   = 1'b0,
    parameter string       FTAG    = "R1"
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic fin
);

    localparam int unsigned W   = N + 1;
    localparam int unsigned LAT = N * (N - 1);
    localparam logic [W-1:0] FPOLY = (W'(1) << N) | W'(1) | (W'(1) << K1) |
        (PENTA ? ((W'(1) << K2) | (W'(1) << K3)) : '0);

    // Stimulus table: {seed for A, seed for B}, expanded to N bits.
    localparam logic [127:0] VEC [0:3] = '{
        128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
        128'h9e37_79b9_7f4a_7c15_bf58_476d_1ce4_e5b9,
        128'h94d0_49bb_1331_11eb_d6e8_feb8_6659_fd93,
        128'h3c6e_f372_fe94_f82b_a54f_f53a_5f1d_36f1
    };

    logic         start;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] c;
    logic         done;

    gf2m_serial_divider #(.N(N), .K1(K1), .K2(K2), .K3(K3), .PENTA(PENTA)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a     (a),
        .b     (b),
        .c     (c),
        .done  (done)
    );

    function automatic logic [N-1:0] expand(input logic [63:0] seed);
        logic [63:0]  s;
        logic [N-1:0] v;
        s = seed | 64'h1;
        v = '0;
        for (int i = 0; i < N; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            v[i] = s[0];
        end
        return v;
    endfunction

    function automatic int degree(input logic [W-1:0] p);
        for (int i = N; i >= 0; i--) begin
            if (p[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [N-1:0] r;
        logic         hi;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            hi = r[N-1];
            r  = r << 1;
            if (hi) r = r ^ FPOLY[N-1:0];
            if (y[i]) r = r ^ x;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] ref_inv(input logic [N-1:0] bv);
        logic [W-1:0] u, v, g1, g2, t;
        int j;
        if (bv == '0) return '0;
        u  = {1'b0, bv};
        v  = FPOLY;
        g1 = W'(1);
        g2 = '0;
        while (u != W'(1)) begin
            j = degree(u) - degree(v);
            if (j < 0) begin
                t = u;  u = v;   v = t;
                t = g1; g1 = g2; g2 = t;
                j = -j;
            end
            u  = u ^ (v << j);
            g1 = g1 ^ (g2 << j);
        end
        return g1[N-1:0];
    endfunction

    function automatic logic [N-1:0] ref_div(input logic [N-1:0] x, input logic [N-1:0] y);
        return ref_mul(x, ref_inv(y));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (N=%0d) %s: actual %h expected %h", req, N, what, act, exp);
        end
    endtask

    task automatic do_div(input logic [N-1:0] av, input logic [N-1:0] bv,
                          output logic [N-1:0] cv, output int lat);
        @(negedge clk);
        start = 1'b1;
        a     = av;
        b     = bv;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        while (!done && lat < LAT + 10) begin
            @(negedge clk);
            lat++;
        end
        cv = c;
    endtask

    initial begin
        logic [N-1:0] av, bv, cv, ev, a2, b2;
        int lat;
        n_chk  = 0;
        n_fail = 0;
        fin    = 1'b0;
        start  = 1'b0;
        a      = '0;
        b      = '0;

        // R7: state while reset is applied and right after its release.
        @(negedge clk);
        check(c == '0 && done == 1'b0, "R7", "outputs in reset", c, '0);
        wait (rst_n === 1'b1);
        @(negedge clk);
        check(c == '0 && done == 1'b0, "R7", "outputs after reset", c, '0);

        // R1 / R2 (and R8 on the trinomial field): table walk.
        for (int v = 0; v < NUM_VEC; v++) begin
            av = expand(VEC[v][127:64]);
            bv = expand(VEC[v][63:0]);
            ev = ref_div(av, bv);
            do_div(av, bv, cv, lat);
            check(cv == ev, FTAG, $sformatf("quotient vector %0d", v), cv, ev);
            check(lat == LAT, "R2", $sformatf("latency vector %0d", v), N'(lat), N'(LAT));
            @(negedge clk);
            check(done == 1'b0, "R2", "strobe width", N'(done), '0);
        end

        // R4: result held while inputs wander and start stays low.
        ev = c;
        a  = ~a;
        b  = b ^ N'(5);
        repeat (3) @(negedge clk);
        check(c == ev, "R4", "quotient held while idle", c, ev);
        check(done == 1'b0, "R4", "no strobe while idle", N'(done), '0);

        // R5: zero divisor.
        av = expand(64'h5555_aaaa_1234_8765);
        do_div(av, '0, cv, lat);
        check(cv == '0, "R5", "zero divisor result", cv, '0);
        check(lat == LAT, "R5", "zero divisor latency", N'(lat), N'(LAT));

        // R6: unit divisor returns the dividend.
        do_div(av, N'(1), cv, lat);
        check(cv == av, "R6", "unit divisor", cv, av);

        if (SMALL) begin
            // R6: zero dividend.
            do_div('0, expand(64'h0f0f_3c3c_9999_7777), cv, lat);
            check(cv == '0, "R6", "zero dividend", cv, '0);

            // R3: a second request during the run is ignored.
            av = expand(64'h1111_2222_3333_4444);
            bv = expand(64'hdead_beef_cafe_f00d) | N'(2);
            a2 = expand(64'h7777_8888_9999_0000);
            b2 = expand(64'h0bad_c0de_1357_2468) | N'(4);
            ev = ref_div(av, bv);
            @(negedge clk);
            start = 1'b1;
            a     = av;
            b     = bv;
            @(negedge clk);
            start = 1'b0;
            lat   = 0;
            repeat (5) begin
                @(negedge clk);
                lat++;
            end
            start = 1'b1;
            a     = a2;
            b     = b2;
            @(negedge clk);
            lat++;
            start = 1'b0;
            while (!done && lat < LAT + 10) begin
                @(negedge clk);
                lat++;
            end
            check(c == ev, "R3", "quotient of first request", c, ev);
            check(lat == LAT, "R3", "latency from first request", N'(lat), N'(LAT));
            cv = c;
            lat = 0;
            repeat (LAT + 4) begin
                @(negedge clk);
                if (done) lat++;
            end
            check(lat == 0, "R3", "no queued division", N'(lat), '0);
            check(c == cv, "R3", "quotient after ignored request", c, cv);
        end

        fin = 1'b1;
    end

endmodule

// File: tb/gf2m_serial_divider_tb_top.sv
module gf2m_serial_divider_tb_top;

    localparam int unsigned WATCHDOG = 195000;

    logic clk;
    logic rst_n;
    int   chk_big, fail_big, chk_small, fail_small;
    logic fin_big, fin_small;
    bit   wd_hit;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // R1: large pentanomial field x^163 + x^7 + x^6 + x^3 + 1.
    gf2m_div_harness #(
        .N(163), .K1(3), .K2(6), .K3(7), .PENTA(1'b1),
        .NUM_VEC(3), .SMALL(1'b0), .FTAG("R1")
    ) big_i (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_big), .n_fail(fail_big), .fin(fin_big)
    );

    // R8: small trinomial field x^7 + x + 1.
    gf2m_div_harness #(
        .N(7), .K1(1), .K2(2), .K3(3), .PENTA(1'b0),
        .NUM_VEC(4), .SMALL(1'b1), .FTAG("R8")
    ) small_i (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_small), .n_fail(fail_small), .fin(fin_small)
    );

    initial begin
        int total_chk;
        int total_fail;
        wd_hit = 1'b0;
        rst_n  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            wait (fin_big === 1'b1 && fin_small === 1'b1);
            begin
                repeat (WATCHDOG) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        total_chk  = chk_big + chk_small;
        total_fail = fail_big + fail_small;
        if (wd_hit) begin
            total_chk++;
            total_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", total_chk, total_fail);
        $finish;
    end

endmodule